// File: doc/BRIEF.md
# Protection FET and Fuse Supervisor

This block is the digital supervisor for the gate enables of a battery pack's protection switches. It drives the enable for the charge-path FET and the discharge-path FET, and the enable for the FET that admits adapter power. It also turns a raw fuse-state sense bit into a latched fuse flag. A safety fault, or software clearing its enable bits, turns the charge and discharge gates off. A fuse indication that persists is handled in two stages. First it is latched. The FETs are then shut off only after a grace interval, and software can cancel that shutdown by clearing the latch before the interval runs out.

All durations are counted in ticks of a slow timebase, which arrives as a one-cycle enable (nominally 1 kHz). The fuse qualification time and the grace interval are parameters given in ticks; at 1 kHz the grace interval defaults to 500 ticks. Every gate enable and the fuse flag come straight from flops.

Top module: `fet_fuse_supervisor`

## Requirements
- R1: While `safetyFault` is 1, `chgGateEn` and `dsgGateEn` are 0 on the cycle after it is sampled.
- R2: With no fault and no fuse trip, `chgGateEn` and `dsgGateEn` follow `chgSwEn` and `dsgSwEn` one cycle later, so writing 0 to both bits turns both gates off.
- R3: If `fuseRaw` is 1 on QUAL_TICKS consecutive tick cycles, `fuseLatched` becomes 1 in the cycle after the last of those ticks. Cycles without `tickEn` do not advance qualification.
- R4: If `fuseRaw` is 0 in any cycle before qualification completes, the qualification count returns to zero, and a further full QUAL_TICKS ticks are then needed.
- R5: If `fuseLatched` stays 1 for GRACE_TICKS ticks, the fuse trips. `chgGateEn` and `dsgGateEn` then go to 0 one cycle later and stay 0 until reset, whatever software does afterwards.
- R6: A one-cycle `fuseClr` pulse clears `fuseLatched` on the next cycle. If it comes before the trip, it cancels the pending shutdown. A later latch then starts a fresh, full grace interval, and it needs a fresh full qualification first.
- R7: `acGateEn` is 1 one cycle after `acSwEn` and `acAboveSense` are both 1, and 0 one cycle after either of them is 0.
- R8: During reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle timebase tick |
| safetyFault | input | 1 | Safety fault present |
| chgSwEn | input | 1 | Software charge-FET enable |
| dsgSwEn | input | 1 | Software discharge-FET enable |
| acSwEn | input | 1 | Software adapter-FET enable |
| acAboveSense | input | 1 | Comparator: adapter voltage above sense node |
| fuseRaw | input | 1 | Raw fuse-state sense |
| fuseClr | input | 1 | Strobe that clears the latched fuse flag |
| chgGateEn | output | 1 | Charge FET gate enable |
| dsgGateEn | output | 1 | Discharge FET gate enable |
| acGateEn | output | 1 | Adapter FET gate enable |
| fuseLatched | output | 1 | Latched fuse status |

## Verification
The hardest case to reach from the ports is a latch that is cleared partway through its grace interval and later set again. The bench has to show that the second grace interval restarts from zero and does not continue from the count the first one reached. To get there, the bench qualifies the fuse, spends part of the grace interval, and clears the latch with the raw input already low. It then requalifies and checks that the gates survive one tick short of a full interval and drop after exactly a full one. The sticky trip is checked by clearing the latch after the shutdown and observing that the gates stay off.

// File: rtl/fet_fuse_pkg.sv
package fet_fuse_pkg;
  typedef struct packed {
    logic qualClr;
    logic qualInc;
    logic graceClr;
    logic graceInc;
    logic fetKill;
  } fuseStrobes_t;
endpackage

// File: rtl/fet_fuse_datapath.sv
module fet_fuse_datapath
  import fet_fuse_pkg::*;
#(
  parameter int QUAL_TICKS  = 8,
  parameter int GRACE_TICKS = 500
) (
  input  logic         clk,
  input  logic         rstN,
  input  fuseStrobes_t strobes,
  input  logic         safetyFault,
  input  logic         chgSwEn,
  input  logic         dsgSwEn,
  input  logic         acSwEn,
  input  logic         acAboveSense,
  output logic         qualHit,
  output logic         graceHit,
  output logic         chgGateEn,
  output logic         dsgGateEn,
  output logic         acGateEn
);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam int GW = $clog2(GRACE_TICKS + 1);
  localparam logic [QW-1:0] QUAL_LAST  = QW'(QUAL_TICKS - 1);
  localparam logic [GW-1:0] GRACE_LAST = GW'(GRACE_TICKS - 1);

  logic [QW-1:0] qualCnt;
  logic [GW-1:0] graceCnt;

  assign qualHit  = strobes.qualInc && !strobes.qualClr && (qualCnt == QUAL_LAST);
  assign graceHit = strobes.graceInc && !strobes.graceClr && (graceCnt == GRACE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (strobes.qualClr || qualHit) begin
      qualCnt <= '0;
    end else if (strobes.qualInc) begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      graceCnt <= '0;
    end else if (strobes.graceClr || graceHit) begin
      graceCnt <= '0;
    end else if (strobes.graceInc) begin
      graceCnt <= graceCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chgGateEn <= 1'b0;
      dsgGateEn <= 1'b0;
      acGateEn  <= 1'b0;
    end else begin
      chgGateEn <= chgSwEn && !safetyFault && !strobes.fetKill;
      dsgGateEn <= dsgSwEn && !safetyFault && !strobes.fetKill;
      acGateEn  <= acSwEn && acAboveSense;
    end
  end

  a_r4_qual_in_range: assert property (@(posedge clk) disable iff (!rstN)
    qualCnt <= QUAL_LAST);
  a_r5_grace_in_range: assert property (@(posedge clk) disable iff (!rstN)
    graceCnt <= GRACE_LAST);
  a_r1_fault_blocks_gates: assert property (@(posedge clk) disable iff (!rstN)
    safetyFault |=> (!chgGateEn && !dsgGateEn));
  a_r7_ac_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    !(acSwEn && acAboveSense) |=> !acGateEn);
endmodule

// File: rtl/fet_fuse_control.sv
module fet_fuse_control
  import fet_fuse_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         fuseRaw,
  input  logic         fuseClr,
  input  logic         qualHit,
  input  logic         graceHit,
  output fuseStrobes_t strobes,
  output logic         fuseLatched
);
  logic fuseTrip;

  always_comb begin
    strobes.qualClr  = !fuseRaw || fuseLatched;
    strobes.qualInc  = tickEn && fuseRaw && !fuseLatched;
    strobes.graceClr = !fuseLatched || fuseClr;
    strobes.graceInc = tickEn && fuseLatched && !fuseTrip;
    strobes.fetKill  = fuseTrip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuseLatched <= 1'b0;
    end else if (qualHit) begin
      fuseLatched <= 1'b1;
    end else if (fuseClr) begin
      fuseLatched <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuseTrip <= 1'b0;
    end else if (graceHit) begin
      fuseTrip <= 1'b1;
    end
  end

  a_r3_latch_needs_raw: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fuseLatched) |-> $past(fuseRaw && tickEn));
  a_r6_clear_drops_latch: assert property (@(posedge clk) disable iff (!rstN)
    (fuseClr && !qualHit) |=> !fuseLatched);
  a_r5_trip_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fuseTrip) |-> $past(fuseLatched));
  a_r5_trip_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fuseTrip |=> fuseTrip);
endmodule

// File: rtl/fet_fuse_supervisor.sv
module fet_fuse_supervisor
  import fet_fuse_pkg::*;
#(
  parameter int QUAL_TICKS  = 8,
  parameter int GRACE_TICKS = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic safetyFault,
  input  logic chgSwEn,
  input  logic dsgSwEn,
  input  logic acSwEn,
  input  logic acAboveSense,
  input  logic fuseRaw,
  input  logic fuseClr,
  output logic chgGateEn,
  output logic dsgGateEn,
  output logic acGateEn,
  output logic fuseLatched
);
  fuseStrobes_t strobes;
  logic qualHit;
  logic graceHit;

  fet_fuse_control ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .fuseRaw(fuseRaw), .fuseClr(fuseClr),
    .qualHit(qualHit), .graceHit(graceHit), .strobes(strobes), .fuseLatched(fuseLatched)
  );

  fet_fuse_datapath #(.QUAL_TICKS(QUAL_TICKS), .GRACE_TICKS(GRACE_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .safetyFault(safetyFault),
    .chgSwEn(chgSwEn), .dsgSwEn(dsgSwEn), .acSwEn(acSwEn), .acAboveSense(acAboveSense),
    .qualHit(qualHit), .graceHit(graceHit),
    .chgGateEn(chgGateEn), .dsgGateEn(dsgGateEn), .acGateEn(acGateEn)
  );

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (rstN || (!chgGateEn && !dsgGateEn && !acGateEn && !fuseLatched)));
endmodule

// File: tb/fet_fuse_supervisor_tb_top.sv
module fet_fuse_supervisor_tb_top;
  localparam int QUAL  = 5;
  localparam int GRACE = 10;

  logic clk = 1'b0;
  logic rstN, tickEn, safetyFault, chgSwEn, dsgSwEn, acSwEn, acAboveSense, fuseRaw, fuseClr;
  logic chgGateEn, dsgGateEn, acGateEn, fuseLatched;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fet_fuse_supervisor #(.QUAL_TICKS(QUAL), .GRACE_TICKS(GRACE)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .safetyFault(safetyFault),
    .chgSwEn(chgSwEn), .dsgSwEn(dsgSwEn), .acSwEn(acSwEn), .acAboveSense(acAboveSense),
    .fuseRaw(fuseRaw), .fuseClr(fuseClr), .chgGateEn(chgGateEn), .dsgGateEn(dsgGateEn),
    .acGateEn(acGateEn), .fuseLatched(fuseLatched)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tickEn = 1'b0; safetyFault = 1'b0; chgSwEn = 1'b1; dsgSwEn = 1'b1;
    acSwEn = 1'b0; acAboveSense = 1'b0; fuseRaw = 1'b0; fuseClr = 1'b0;
    cyc(3);
    check("R8 chg in reset", chgGateEn, 1'b0);
    check("R8 dsg in reset", dsgGateEn, 1'b0);
    check("R8 ac in reset", acGateEn, 1'b0);
    check("R8 fuse in reset", fuseLatched, 1'b0);
    rstN = 1'b1;
    cyc(2);
  endtask

  task automatic pulseClr();
    fuseClr = 1'b1;
    @(negedge clk);
    fuseClr = 1'b0;
  endtask

  task automatic testSwAndFault();
    check("R2 chg follows sw", chgGateEn, 1'b1);
    check("R2 dsg follows sw", dsgGateEn, 1'b1);
    chgSwEn = 1'b0; dsgSwEn = 1'b0;
    cyc(1);
    check("R2 chg off", chgGateEn, 1'b0);
    check("R2 dsg off", dsgGateEn, 1'b0);
    chgSwEn = 1'b1;
    cyc(1);
    check("R2 chg alone on", chgGateEn, 1'b1);
    check("R2 dsg stays off", dsgGateEn, 1'b0);
    dsgSwEn = 1'b1; safetyFault = 1'b1;
    cyc(1);
    check("R1 fault chg off", chgGateEn, 1'b0);
    check("R1 fault dsg off", dsgGateEn, 1'b0);
    safetyFault = 1'b0;
    cyc(1);
    check("R1 recovery chg", chgGateEn, 1'b1);
    check("R1 recovery dsg", dsgGateEn, 1'b1);
  endtask

  task automatic testAc();
    acSwEn = 1'b1; acAboveSense = 1'b0;
    cyc(1);
    check("R7 comparator low", acGateEn, 1'b0);
    acAboveSense = 1'b1;
    cyc(1);
    check("R7 both high", acGateEn, 1'b1);
    acSwEn = 1'b0;
    cyc(1);
    check("R7 sw low", acGateEn, 1'b0);
  endtask

  task automatic testQual();
    fuseRaw = 1'b1;
    cyc(40);
    check("R3 no ticks no latch", fuseLatched, 1'b0);
    ticks(QUAL - 1);
    check("R4 one short", fuseLatched, 1'b0);
    fuseRaw = 1'b0;
    cyc(1);
    fuseRaw = 1'b1;
    ticks(QUAL - 1);
    check("R4 restart needed", fuseLatched, 1'b0);
    ticks(1);
    check("R3 latched", fuseLatched, 1'b1);
    check("R3 gates still on", chgGateEn, 1'b1);
  endtask

  task automatic testTrip();
    ticks(GRACE - 1);
    check("R5 before expiry", chgGateEn, 1'b1);
    ticks(1);
    check("R5 chg tripped", chgGateEn, 1'b0);
    check("R5 dsg tripped", dsgGateEn, 1'b0);
    fuseRaw = 1'b0;
    pulseClr();
    cyc(2);
    check("R6 clear drops flag", fuseLatched, 1'b0);
    check("R5 trip sticky", chgGateEn, 1'b0);
  endtask

  task automatic testCancel();
    fuseRaw = 1'b1;
    ticks(QUAL);
    check("R3 latch again", fuseLatched, 1'b1);
    ticks(GRACE - 4);
    fuseRaw = 1'b0;
    pulseClr();
    check("R6 cleared", fuseLatched, 1'b0);
    ticks(GRACE + 2);
    check("R6 cancel keeps chg", chgGateEn, 1'b1);
    check("R6 cancel keeps dsg", dsgGateEn, 1'b1);
    fuseRaw = 1'b1;
    ticks(QUAL - 1);
    check("R6 requalify needed", fuseLatched, 1'b0);
    ticks(1);
    check("R6 relatched", fuseLatched, 1'b1);
    ticks(GRACE - 1);
    check("R6 grace restarted", chgGateEn, 1'b1);
    ticks(1);
    check("R6 full grace trips", dsgGateEn, 1'b0);
  endtask

  initial begin
    doReset();
    testSwAndFault();
    testAc();
    testQual();
    testTrip();
    doReset();
    testCancel();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule